// File: doc/BRIEF.md
# AES Column Round Slice

This block computes one 32-bit column of an AES-128 encryption round in a datapath that finishes one round per clock. The row rotation step is done on the wiring in front of the block, so each slice receives a column whose bytes have already been gathered from the right source columns. Each slice stores that column, substitutes each of its four bytes through the AES S-box, mixes the column, and adds a 32-bit round-key word by XOR. A control input skips the mixing step in the final round.

Four identical slices side by side form a full 128-bit round. Because rotation sits ahead of the register, a slice has no dependence on its neighbours, so slices can be replicated or swapped freely. The key schedule, the rotation wiring and the round counter sit outside. The register updates on a clock edge. The result is combinational from the stored column and from the current round key and last-round control.

Top module: `aes_col_slice`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the stored column is cleared to zero whatever `load` is. With a cleared column, `col_out` equals 0x63636363 XOR `round_key` in both modes.
- R2: At a rising edge with `rst_n` high, `load` high stores `col_in`. With `load` low the stored column and `col_out` stay unchanged, even when `col_in` changes.
- R3: Each byte is substituted by its multiplicative inverse in GF(2^8), reduced by 0x11B, with 0x00 mapping to 0x00. An affine step with constant 0x63 follows. Examples: 0x00→0x63, 0x01→0x7C, 0x53→0xED, 0xFF→0x16.
- R4: When `last_round` is low, the substituted column (row 0 = bits 31:24, row 3 = bits 7:0) is multiplied by {03}x^3+{01}x^2+{01}x+{02} modulo x^4+1. Output row r = 2·a[r] ⊕ 3·a[r+1] ⊕ a[r+2] ⊕ a[r+3], with indices taken mod 4.
- R5: When `last_round` is high, the substituted column goes straight to the key addition and is not mixed.
- R6: `col_out` is the selected column XOR `round_key`, bit for bit.
- R7: `col_out` follows changes of `round_key` and `last_round` in the same cycle, with no clock edge needed.
- R8: Four slices, given the rotated state columns and the round-key words for rounds 1 to 10 (the last with `last_round` high), produce the AES-128 ciphertext in 10 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the column register |
| load | input | 1 | Store `col_in` at the next rising edge |
| last_round | input | 1 | Skip column mixing (final round) |
| col_in | input | 32 | Rotated input column, row 0 in bits 31:24 |
| round_key | input | 32 | Round-key word for this column |
| col_out | output | 32 | Round result for this column |

## Verification
A column presented with `load` high appears at `col_out` after exactly one rising edge. The bench drives inputs on the falling edge and checks at the following falling edge, half a cycle after the loading edge. Changes to the round key or the last-round control are due with no edge at all, so the bench checks them a few nanoseconds after driving them, while the clock is low. The ten-round encryption feeds each sampled round result back through the rotation, sampling once per cycle on the falling edge, and compares the final state with a known ciphertext.

// File: rtl/aes_slice_pkg.sv
// Package: GF(2^8) arithmetic and S-box helpers shared by the column slice.
// Assumes the field polynomial x^8+x^4+x^3+x+1 and 8-bit bytes.
package aes_slice_pkg;

    localparam int GF_W = 8;
    localparam logic [GF_W-1:0] GF_RED    = 8'h1B;
    localparam logic [GF_W-1:0] AFF_CONST = 8'h63;

    typedef logic [GF_W-1:0] gf_byte_t;

    // Multiply by x: shift left, fold the carried bit back through the field polynomial.
    function automatic gf_byte_t gf_dbl(input gf_byte_t a);
        return {a[GF_W-2:0], 1'b0} ^ (a[GF_W-1] ? GF_RED : '0);
    endfunction

    // General field product by shift-and-add.
    function automatic gf_byte_t gf_mul(input gf_byte_t a, input gf_byte_t b);
        gf_byte_t acc;
        gf_byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < GF_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

    // Inverse as a^254 by an addition chain; zero maps to zero.
    function automatic gf_byte_t gf_inv(input gf_byte_t a);
        gf_byte_t p2, p3, p12, p15, p240;
        p2   = gf_mul(a, a);
        p3   = gf_mul(p2, a);
        p12  = gf_mul(gf_mul(p3, p3), gf_mul(p3, p3));
        p15  = gf_mul(p12, p3);
        p240 = gf_mul(p15, p15);
        p240 = gf_mul(p240, p240);
        p240 = gf_mul(p240, p240);
        p240 = gf_mul(p240, p240);
        return gf_mul(gf_mul(p240, p12), p2);
    endfunction

    // Left rotation of a byte.
    function automatic gf_byte_t rotl_byte(input gf_byte_t b, input int n);
        return gf_byte_t'((b << n) | (b >> (GF_W - n)));
    endfunction

    // Affine step over GF(2) with the fixed constant.
    function automatic gf_byte_t sbox_affine(input gf_byte_t b);
        return b ^ rotl_byte(b, 1) ^ rotl_byte(b, 2) ^ rotl_byte(b, 3)
                 ^ rotl_byte(b, 4) ^ AFF_CONST;
    endfunction

endpackage

// File: rtl/aes_sbox_byte.sv
// aes_sbox_byte: combinational AES byte substitution.
// Computes the field inverse and then the affine step; no table is stored.
module aes_sbox_byte
    import aes_slice_pkg::*;
(
    input  logic [GF_W-1:0] byte_in,
    output logic [GF_W-1:0] byte_out
);

    // Substitute the byte: inverse followed by affine map.
    always_comb begin
        byte_out = sbox_affine(gf_inv(byte_in));
    end

endmodule

// File: rtl/aes_mix_column.sv
// aes_mix_column: multiplies one column by the fixed MixColumns polynomial.
// Row 0 sits in the most significant byte; the coefficients assume ROWS = 4.
module aes_mix_column
    import aes_slice_pkg::*;
#(
    parameter int ROWS = 4
) (
    input  logic [ROWS*GF_W-1:0] col_in,
    output logic [ROWS*GF_W-1:0] col_out
);

    localparam int COL_W = ROWS * GF_W;

    logic [GF_W-1:0] a [ROWS];

    // Split the column into rows, row 0 at the top.
    always_comb begin
        for (int r = 0; r < ROWS; r++)
            a[r] = col_in[COL_W-1-r*GF_W -: GF_W];
    end

    // One output row per generate step: 2*a[r] ^ 3*a[r+1] ^ a[r+2] ^ a[r+3].
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam int R1I = (r + 1) % ROWS;
        localparam int R2I = (r + 2) % ROWS;
        localparam int R3I = (r + 3) % ROWS;
        always_comb begin
            col_out[COL_W-1-r*GF_W -: GF_W] =
                gf_dbl(a[r]) ^ gf_dbl(a[R1I]) ^ a[R1I] ^ a[R2I] ^ a[R3I];
        end
    end

endmodule

// File: rtl/aes_col_reg.sv
// aes_col_reg: column state register with synchronous active-low clear and load enable.
// Clear takes priority over load.
module aes_col_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Hold, load or clear the stored column.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/aes_col_slice.sv
// aes_col_slice: one column of a one-round-per-clock AES-128 encryption round.
// Expects an already row-rotated column; applies S-boxes, optional mixing, key XOR.
// The output is combinational from the register, the round key and last_round.
module aes_col_slice
    import aes_slice_pkg::*;
#(
    parameter int ROWS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 last_round,
    input  logic [ROWS*GF_W-1:0] col_in,
    input  logic [ROWS*GF_W-1:0] round_key,
    output logic [ROWS*GF_W-1:0] col_out
);

    localparam int COL_W = ROWS * GF_W;

    logic [COL_W-1:0] state_q;
    logic [COL_W-1:0] sub_word;
    logic [COL_W-1:0] mix_word;
    logic [COL_W-1:0] pre_key;

    aes_col_reg #(.WIDTH(COL_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     (col_in),
        .q     (state_q)
    );

    // One S-box per row of the column.
    for (genvar r = 0; r < ROWS; r++) begin : g_sbox
        aes_sbox_byte u_sb (
            .byte_in  (state_q[COL_W-1-r*GF_W -: GF_W]),
            .byte_out (sub_word[COL_W-1-r*GF_W -: GF_W])
        );

        // S-box has neither fixed points nor complement fixed points.
        assert_sbox_nofix_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (sub_word[COL_W-1-r*GF_W -: GF_W] != state_q[COL_W-1-r*GF_W -: GF_W]) &&
            (sub_word[COL_W-1-r*GF_W -: GF_W] != ~state_q[COL_W-1-r*GF_W -: GF_W]));
    end

    aes_mix_column #(.ROWS(ROWS)) u_mix (
        .col_in  (sub_word),
        .col_out (mix_word)
    );

    // Bypass the mixing in the final round, then add the round key.
    always_comb begin
        pre_key = last_round ? sub_word : mix_word;
        col_out = pre_key ^ round_key;
    end

    // XOR of all bytes of a column.
    function automatic logic [GF_W-1:0] byte_fold(input logic [COL_W-1:0] w);
        logic [GF_W-1:0] f;
        f = '0;
        for (int r = 0; r < ROWS; r++) f = f ^ w[r*GF_W +: GF_W];
        return f;
    endfunction

    // Reset clears the register.
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> state_q == '0);

    // Load captures the input column.
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> state_q == $past(col_in));

    // Without load the register holds.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> state_q == $past(state_q));

    // Mixing keeps the byte-wise XOR of the column (coefficients sum to one).
    assert_mix_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !last_round |-> byte_fold(col_out ^ round_key) == byte_fold(sub_word));

endmodule

// File: tb/aes_col_slice_tb.sv
// aes_col_slice_tb: directed and seeded-random checks of one slice against bench
// reference functions, plus a full AES-128 encryption through four slices.
module aes_col_slice_tb;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic        rst_n, load, last_round;
    logic [31:0] col_in, round_key, col_out;

    aes_col_slice u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .last_round(last_round),
        .col_in(col_in), .round_key(round_key), .col_out(col_out)
    );

    logic        e_load, e_last;
    logic [31:0] e_in [4];
    logic [31:0] e_key[4];
    logic [31:0] e_out[4];

    for (genvar c = 0; c < 4; c++) begin : g_enc
        aes_col_slice u_enc (
            .clk(clk), .rst_n(rst_n), .load(e_load), .last_round(e_last),
            .col_in(e_in[c]), .round_key(e_key[c]), .col_out(e_out[c])
        );
    end

    // Bench field tables built from generator 3.
    logic [7:0] exp_t [256];
    int         log_t [256];

    function automatic logic [7:0] tb_x2(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [7:0] tb_rl(input logic [7:0] b, input int n);
        return 8'((b << n) | (b >> (8 - n)));
    endfunction

    function automatic logic [7:0] tb_sbox(input logic [7:0] x);
        logic [7:0] v;
        v = (x == 8'h00) ? 8'h00 : exp_t[(255 - log_t[x]) % 255];
        return v ^ tb_rl(v, 1) ^ tb_rl(v, 2) ^ tb_rl(v, 3) ^ tb_rl(v, 4) ^ 8'h63;
    endfunction

    function automatic logic [31:0] tb_subw(input logic [31:0] w);
        return {tb_sbox(w[31:24]), tb_sbox(w[23:16]), tb_sbox(w[15:8]), tb_sbox(w[7:0])};
    endfunction

    function automatic logic [31:0] tb_mix(input logic [31:0] w);
        logic [7:0] a [4];
        logic [31:0] o;
        for (int r = 0; r < 4; r++) a[r] = w[31-8*r -: 8];
        for (int r = 0; r < 4; r++)
            o[31-8*r -: 8] = tb_x2(a[r]) ^ tb_x2(a[(r+1)%4]) ^ a[(r+1)%4]
                             ^ a[(r+2)%4] ^ a[(r+3)%4];
        return o;
    endfunction

    function automatic logic [31:0] tb_ref(input logic [31:0] col, input logic [31:0] key,
                                           input logic last);
        logic [31:0] s;
        s = tb_subw(col);
        return (last ? s : tb_mix(s)) ^ key;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Load one column and check it one edge later.
    task automatic load_and_check(input string tag, input logic [31:0] c,
                                  input logic [31:0] k, input logic l);
        @(negedge clk);
        load = 1'b1; col_in = c; round_key = k; last_round = l;
        @(negedge clk);
        load = 1'b0;
        check(tag, col_out, tb_ref(c, k, l));
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]   x;
        logic [31:0]  w [44];
        logic [7:0]   rc;
        logic [127:0] st;
        logic [31:0]  c0, k0, k1;
        int unsigned  sd;

        x = 8'h01;
        for (int i = 0; i < 255; i++) begin
            exp_t[i] = x; log_t[x] = i;
            x = x ^ tb_x2(x);
        end
        exp_t[255] = 8'h01; log_t[0] = 0;
        sd = $urandom(32'h5A17C0DE);

        rst_n = 1'b0; load = 1'b1; last_round = 1'b0;
        col_in = 32'hDEADBEEF; round_key = 32'h0;
        e_load = 1'b0; e_last = 1'b0;
        for (int c = 0; c < 4; c++) begin e_in[c] = '0; e_key[c] = '0; end

        // R1: reset wins over load; cleared column gives 0x63 bytes.
        @(negedge clk); @(negedge clk);
        check("R1 reset mix", col_out, 32'h63636363);
        round_key = 32'h0F0F1234; last_round = 1'b1; #1;
        check("R1 reset last", col_out, 32'h63636363 ^ 32'h0F0F1234);
        @(negedge clk);
        rst_n = 1'b1; load = 1'b0; last_round = 1'b0; round_key = '0;

        // R3: known substitutions, viewed through the bypass with zero key.
        load_and_check("R3 sbox", 32'h000153FF, 32'h0, 1'b1);
        check("R3 sbox const", col_out, 32'h637CED16);

        // R6: key XOR on a known substituted column.
        load_and_check("R6 key", 32'h00000000, 32'hA5A55A5A, 1'b1);
        check("R6 key const", col_out, 32'h63636363 ^ 32'hA5A55A5A);

        // R4 and R5 on directed patterns.
        load_and_check("R4 mix ones", 32'hFFFFFFFF, 32'h0, 1'b0);
        load_and_check("R4 mix ramp", 32'h01020304, 32'h11223344, 1'b0);
        load_and_check("R5 bypass ramp", 32'h01020304, 32'h11223344, 1'b1);

        // Seeded random columns, keys and modes.
        for (int i = 0; i < 300; i++) begin
            c0 = $urandom; k0 = $urandom;
            load_and_check(i[0] ? "R5 random" : "R4 random", c0, k0, i[0]);

            // R7: key and mode change with no edge.
            k1 = $urandom;
            round_key = k1; last_round = ~last_round; #1;
            check("R7 comb", col_out, tb_ref(c0, k1, last_round));

            // R2: input change without load leaves output alone.
            col_in = $urandom;
            @(negedge clk);
            check("R2 hold", col_out, tb_ref(c0, k1, last_round));
        end

        // R8: key expansion and full encryption through four slices.
        w[0] = 32'h00010203; w[1] = 32'h04050607; w[2] = 32'h08090A0B; w[3] = 32'h0C0D0E0F;
        rc = 8'h01;
        for (int i = 4; i < 44; i++) begin
            logic [31:0] t;
            t = w[i-1];
            if (i % 4 == 0) begin
                t = tb_subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = tb_x2(rc);
            end
            w[i] = w[i-4] ^ t;
        end
        st = 128'h00112233445566778899AABBCCDDEEFF ^ {w[0], w[1], w[2], w[3]};
        @(negedge clk);
        for (int r = 1; r <= 10; r++) begin
            for (int c = 0; c < 4; c++) begin
                for (int q = 0; q < 4; q++)
                    e_in[c][31-8*q -: 8] = st[127-8*(4*((c+q)%4)+q) -: 8];
                e_key[c] = w[4*r+c];
            end
            e_load = 1'b1; e_last = (r == 10);
            @(negedge clk);
            st = {e_out[0], e_out[1], e_out[2], e_out[3]};
        end
        e_load = 1'b0;
        check("R8 ct hi", st[127:96], 32'h69C4E0D8);
        check("R8 ct m1", st[95:64],  32'h6A7B0430);
        check("R8 ct m2", st[63:32],  32'hD8CDB780);
        check("R8 ct lo", st[31:0],   32'h70B4C55A);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule